// File: doc/BRIEF.md
# Gated Clock and Idle Controller

This block sits in a peripheral controller chip and produces one clock-enable strobe for each functional unit. It also produces a gate for the processor clock. It runs on a single fast clock of 24 MHz. Software writes an enable bit and a 4-bit rate code for each unit through a simple write-only register port. A unit whose enable bit is clear receives no strobes. An enabled unit receives a one-cycle strobe every (code+1) fast cycles, so it runs only as fast as it needs to.

A one-cycle idle command forces every enabled unit down to a fixed strobe every 16 fast cycles (1.5 MHz). The event-waiting state machines keep running at this slow rate. A separate one-cycle stop command drops the processor clock gate. A wake-event line that is not masked ends both conditions. The processor gate comes back within two fast cycles, and each unit returns to its programmed rate at its next period boundary. Configuration changes, entering idle and leaving idle all take effect only at a unit's period boundary. As a result, a period is never cut short and no strobe is ever clipped.

Top module: `ckg_ctrl`

## Requirements
- R1: After synchronous reset, all unit strobes are low, `idle_mode` is 0 and `cpu_clk_en` is 1. All units are disabled with rate code 0, and all wake lines are unmasked.
- R2: A unit whose enable bit is clear produces no strobe.
- R3: Address k (k < 8) holds unit k's configuration. `wr_data[4]` is the enable bit and `wr_data[3:0]` is the rate code c. An enabled unit, outside idle, emits a one-cycle strobe every c+1 fast cycles, for every c from 0 to 15.
- R4: Address 8 holds the wake mask in `wr_data[3:0]`. Bit i set means that wake line i may wake the system. A wake pulse on a masked line has no effect.
- R5: A configuration change takes effect only at the unit's next period boundary. The period in progress completes with its strobe, and only then does the new rate or enable apply.
- R6: A one-cycle `idle_req` sets `idle_mode` two cycles later. While idle, every enabled unit strobes once every 16 cycles from its next boundary on, and disabled units stay silent.
- R7: An unmasked wake pulse clears `idle_mode` two cycles later. Each unit returns to its programmed rate from its next boundary.
- R8: A one-cycle `cpu_stop_req` clears `cpu_clk_en` two cycles later. It stays cleared until an unmasked wake pulse, which sets it again two cycles after the pulse.
- R9: When an unmasked wake pulse arrives in the same cycle as `idle_req` or `cpu_stop_req`, the wake wins. Idle is not entered and the processor clock is not stopped.
- R10: Writes to addresses 9 to 15 change no unit configuration and no wake mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 24 MHz |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0-7 unit config, 8 wake mask |
| wr_data | input | 5 | Write data |
| idle_req | input | 1 | One-cycle idle command |
| cpu_stop_req | input | 1 | One-cycle processor clock stop command |
| wake_evt | input | 4 | Wake-event lines, one-cycle pulses |
| unit_ce | output | 8 | Per-unit clock-enable strobes |
| idle_mode | output | 1 | High while the idle rate is in force |
| cpu_clk_en | output | 1 | Processor clock gate |

## Verification
The assertions watch the mode handshakes on every cycle. Idle and the processor stop may begin only two cycles after their command and with no unmasked wake pending. They may end only two cycles after an unmasked wake. Once idle has lasted long enough, no unit may strobe on two cycles in a row. The exact strobe period for each rate code, the boundary-aligned hand-over of rate and enable changes, the masking of wake lines and the ignored addresses are shown only by the bench scenarios. These scenarios measure the gaps between strobes and compare them with the gaps the programmed codes predict.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_UNIT = 2'd1,
    SEL_WAKE = 2'd2
  } reg_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ckg_cfg_regs.sv
module ckg_cfg_regs
  import ckg_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DIV_W     = 4,
  parameter int NUM_WAKE  = 4,
  parameter int AW        = 4,
  parameter int DW        = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic [NUM_UNITS-1:0]       prog_en,
  output logic [NUM_UNITS*DIV_W-1:0] prog_div,
  output logic [NUM_WAKE-1:0]        wake_mask
);
  reg_sel_e sel;

  always_comb begin
    if (!wr_en)                       sel = SEL_NONE;
    else if (wr_addr < AW'(NUM_UNITS)) sel = SEL_UNIT;
    else if (wr_addr == AW'(NUM_UNITS)) sel = SEL_WAKE;
    else                              sel = SEL_NONE;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        prog_en[u]                  <= 1'b0;
        prog_div[u*DIV_W +: DIV_W]  <= '0;
      end else if (sel == SEL_UNIT && wr_addr == AW'(u)) begin
        prog_en[u]                  <= wr_data[DIV_W];
        prog_div[u*DIV_W +: DIV_W]  <= wr_data[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   wake_mask <= '1;
    else if (sel == SEL_WAKE)  wake_mask <= wr_data[NUM_WAKE-1:0];
  end
endmodule

// File: rtl/ckg_unit_div.sv
module ckg_unit_div #(
  parameter int DIV_W    = 4,
  parameter int IDLE_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             prog_en,
  input  logic [DIV_W-1:0] prog_div,
  output logic             ce
);
  localparam logic [DIV_W-1:0] IDLE_LIM = DIV_W'(IDLE_DIV - 1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_act;
  logic             en_act;
  logic             boundary;

  assign boundary = (cnt == lim_act);

  // Rate and enable are latched only when a period ends, so every
  // period runs to completion and each strobe is a full cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim_act <= '0;
      en_act  <= 1'b0;
      ce      <= 1'b0;
    end else begin
      ce <= en_act & boundary;
      if (boundary) begin
        cnt     <= '0;
        lim_act <= idle ? IDLE_LIM : prog_div;
        en_act  <= prog_en;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ckg_power_fsm.sv
module ckg_power_fsm #(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle_req,
  input  logic                cpu_stop_req,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_mask,
  output logic                idle_mode,
  output logic                cpu_run,
  output logic                wake_pend
);
  logic idle_cmd_r;
  logic stop_cmd_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cmd_r <= 1'b0;
      stop_cmd_r <= 1'b0;
      wake_pend  <= 1'b0;
      idle_mode  <= 1'b0;
      cpu_run    <= 1'b1;
    end else begin
      idle_cmd_r <= idle_req;
      stop_cmd_r <= cpu_stop_req;
      wake_pend  <= |(wake_evt & wake_mask);
      if (wake_pend) begin
        idle_mode <= 1'b0;
        cpu_run   <= 1'b1;
      end else begin
        if (idle_cmd_r) idle_mode <= 1'b1;
        if (stop_cmd_r) cpu_run   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DIV_W     = 4,
  parameter int NUM_WAKE  = 4,
  parameter int IDLE_DIV  = 16,
  localparam int AW       = $clog2(NUM_UNITS) + 1,
  localparam int DW       = max2(DIV_W + 1, NUM_WAKE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 idle_req,
  input  logic                 cpu_stop_req,
  input  logic [NUM_WAKE-1:0]  wake_evt,
  output logic [NUM_UNITS-1:0] unit_ce,
  output logic                 idle_mode,
  output logic                 cpu_clk_en
);
  logic [NUM_UNITS-1:0]       prog_en;
  logic [NUM_UNITS*DIV_W-1:0] prog_div;
  logic [NUM_WAKE-1:0]        wake_mask_w;
  logic                       wake_pend;

  ckg_cfg_regs #(
    .NUM_UNITS(NUM_UNITS), .DIV_W(DIV_W), .NUM_WAKE(NUM_WAKE),
    .AW(AW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_en(prog_en), .prog_div(prog_div),
    .wake_mask(wake_mask_w)
  );

  ckg_power_fsm #(.NUM_WAKE(NUM_WAKE)) u_pwr (
    .clk(clk), .rst(rst), .idle_req(idle_req),
    .cpu_stop_req(cpu_stop_req), .wake_evt(wake_evt),
    .wake_mask(wake_mask_w), .idle_mode(idle_mode),
    .cpu_run(cpu_clk_en), .wake_pend(wake_pend)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_div
    ckg_unit_div #(.DIV_W(DIV_W), .IDLE_DIV(IDLE_DIV)) u_div (
      .clk(clk), .rst(rst), .idle(idle_mode),
      .prog_en(prog_en[u]), .prog_div(prog_div[u*DIV_W +: DIV_W]),
      .ce(unit_ce[u])
    );
  end
endmodule

// File: rtl/ckg_ctrl_chk.sv
module ckg_ctrl_chk #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_WAKE  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 idle_req,
  input logic                 cpu_stop_req,
  input logic [NUM_WAKE-1:0]  wake_evt,
  input logic [NUM_WAKE-1:0]  wake_mask,
  input logic                 wake_pend,
  input logic [NUM_UNITS-1:0] unit_ce,
  input logic                 idle_mode,
  input logic                 cpu_clk_en
);
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_mode) |-> ($past(idle_req, 2) && (($past(wake_evt, 2) & $past(wake_mask, 2)) == '0))); // R6

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_mode) |-> (($past(wake_evt, 2) & $past(wake_mask, 2)) != '0)); // R7

  AST_CPU_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_clk_en) |-> ($past(cpu_stop_req, 2) && (($past(wake_evt, 2) & $past(wake_mask, 2)) == '0))); // R8

  AST_CPU_WAKE: assert property (@(posedge clk) disable iff (rst)
    wake_pend |=> (cpu_clk_en && !idle_mode)); // R9

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slow
    AST_IDLE_SLOW: assert property (@(posedge clk) disable iff (rst)
      (idle_mode && $past(idle_mode) && $past(idle_mode, 2) && $past(unit_ce[u])) |-> !unit_ce[u]); // R6
  end
endmodule

bind ckg_ctrl ckg_ctrl_chk #(.NUM_UNITS(NUM_UNITS), .NUM_WAKE(NUM_WAKE)) u_chk (
  .clk(clk), .rst(rst), .idle_req(idle_req), .cpu_stop_req(cpu_stop_req),
  .wake_evt(wake_evt), .wake_mask(wake_mask_w), .wake_pend(wake_pend),
  .unit_ce(unit_ce), .idle_mode(idle_mode), .cpu_clk_en(cpu_clk_en)
);

// File: tb/ckg_ctrl_test.sv
module ckg_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic       idle_req = 1'b0;
  logic       cpu_stop_req = 1'b0;
  logic [3:0] wake_evt = '0;
  logic [7:0] unit_ce;
  logic       idle_mode;
  logic       cpu_clk_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ckg_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle_req(idle_req), .cpu_stop_req(cpu_stop_req), .wake_evt(wake_evt),
    .unit_ce(unit_ce), .idle_mode(idle_mode), .cpu_clk_en(cpu_clk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Cycles from one strobe of unit u to the next; -1 on timeout.
  task automatic gap(input int u, output int g);
    int w = 0;
    g = -1;
    while (!unit_ce[u] && w < 64) begin @(negedge clk); w++; end
    if (!unit_ce[u]) return;
    for (int n = 1; n <= 64; n++) begin
      @(negedge clk);
      if (unit_ce[u]) begin g = n; return; end
    end
  endtask

  task automatic count_pulses(input int u, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (unit_ce[u]) c++; end
  endtask

  task automatic pulse_wake(input logic [3:0] w, input bit idl, input bit stp);
    @(negedge clk); wake_evt = w; idle_req = idl; cpu_stop_req = stp;
    @(negedge clk); wake_evt = '0; idle_req = 1'b0; cpu_stop_req = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    int g, c, tot;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 unit_ce", unit_ce, 0);
    check("R1 idle_mode", idle_mode, 0);
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    tot = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); tot += $countones(unit_ce); end
    check("R1 R2 no strobes after reset", tot, 0);

    // R3 sweep of every rate code
    for (int r = 0; r < 2; r++) begin
      for (int u = 0; u < 8; u++) wr(4'(u), {1'b1, 4'(r*8+u)});
      tick(40);
      for (int u = 0; u < 8; u++) begin
        gap(u, g);
        check($sformatf("R3 unit%0d code%0d gap", u, r*8+u), g, r*8+u+1);
      end
    end

    // R2 disabled unit stays silent
    wr(4'd3, 5'h00);
    tick(40);
    count_pulses(3, 40, c);
    check("R2 disabled unit strobes", c, 0);

    // R5 disable mid-period: current period completes, then silence
    wr(4'd0, {1'b1, 4'd15});
    tick(40);
    gap(0, g);
    tick(4);
    wr(4'd0, 5'h00);
    c = 0;
    for (int n = 1; n <= 40; n++) begin @(negedge clk); if (unit_ce[0] && c == 0) c = n + 6; end
    check("R5 last strobe after disable", c, 16);
    count_pulses(0, 40, c);
    check("R5 silent after boundary", c, 0);

    // R5 rate change mid-period
    wr(4'd1, {1'b1, 4'd15});
    tick(40);
    gap(1, g);
    tick(2);
    wr(4'd1, {1'b1, 4'd2});
    gap(1, g);
    check("R5 old period completes", g, 3);
    gap(1, g);
    check("R5 new period applies", g, 3);

    // R6 idle mode
    wr(4'd0, {1'b1, 4'd0});
    wr(4'd1, {1'b1, 4'd5});
    wr(4'd2, {1'b0, 4'd9});
    pulse_wake(4'b0000, 1'b1, 1'b0);
    tick(1);
    check("R6 idle_mode set", idle_mode, 1);
    tick(40);
    gap(0, g); check("R6 unit0 idle gap", g, 16);
    gap(1, g); check("R6 unit1 idle gap", g, 16);
    count_pulses(2, 40, c); check("R6 disabled unit in idle", c, 0);

    // R4 masked wake line
    wr(4'd8, 5'b00001);
    pulse_wake(4'b0010, 1'b0, 1'b0);
    tick(3);
    check("R4 masked wake ignored", idle_mode, 1);
    tick(20);
    gap(0, g); check("R4 rate unchanged by masked wake", g, 16);

    // R7 wake exits idle
    pulse_wake(4'b0001, 1'b0, 1'b0);
    tick(1);
    check("R7 idle_mode cleared", idle_mode, 0);
    tick(40);
    gap(0, g); check("R7 unit0 rate restored", g, 1);
    gap(1, g); check("R7 unit1 rate restored", g, 6);

    // R8 processor clock stop and wake
    pulse_wake(4'b0000, 1'b0, 1'b1);
    tick(1);
    check("R8 cpu stopped", cpu_clk_en, 0);
    tick(10);
    check("R8 cpu stays stopped", cpu_clk_en, 0);
    pulse_wake(4'b0010, 1'b0, 1'b0);
    tick(3);
    check("R4 masked wake keeps cpu stopped", cpu_clk_en, 0);
    pulse_wake(4'b0001, 1'b0, 1'b0);
    tick(1);
    check("R8 cpu released", cpu_clk_en, 1);

    // R9 wake wins over simultaneous commands
    pulse_wake(4'b0001, 1'b1, 1'b1);
    tick(3);
    check("R9 idle not entered", idle_mode, 0);
    check("R9 cpu not stopped", cpu_clk_en, 1);

    // R10 writes above the wake-mask address are ignored
    for (int a = 9; a < 16; a++) wr(4'(a), 5'h1F);
    tick(40);
    gap(0, g); check("R10 unit0 config kept", g, 1);
    count_pulses(2, 40, c); check("R10 unit2 still disabled", c, 0);
    pulse_wake(4'b0000, 1'b1, 1'b0);
    tick(3);
    pulse_wake(4'b0010, 1'b0, 1'b0);
    tick(3);
    check("R10 wake mask kept", idle_mode, 1);
    pulse_wake(4'b0001, 1'b0, 1'b0);
    tick(3);
    check("R10 unmasked line still wakes", idle_mode, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule